// File: doc/BRIEF.md
# Two-Digit BCD Down Counter with Cascade Output

This block is a presettable decimal down counter built from two BCD digits, tens and units, so its value runs from 99 down to 00. On every rising clock edge the value drops by one. At 00 the next edge brings it back to 99, which gives a free-running cycle of 100 clocks. All controls are active-low except the count inhibit, which is active-high. A clear sends the counter to 99 at once. An immediate load copies the preset bus into the counter at once, without waiting for a clock. A clocked load copies the preset bus on the next rising edge.

An active-low terminal flag is low while the counter reads 00 and counting is allowed. The flag is combinational. A second stage can therefore take the flag on its inhibit input and step on the same edge on which the first stage wraps. Two stages built this way form a four-digit counter with 10000 states. Typical uses are programmable dividers and interval timers.

Top module: `bcd_down_counter`

## Requirements
- R1: With clr_n, aload_n and sload_n high and inhibit low, each rising clock edge lowers the value by one in decimal. When the units digit is 0 it becomes 9, and the tens digit drops by one on the same edge.
- R2: While clr_n is low, count reads 8'h99 at once, with no clock edge needed. This holds whatever the other inputs are.
- R3: While aload_n is low and clr_n is high, count equals preset at once, with no clock edge needed. A clock edge, sload_n and inhibit cannot change it during that time.
- R4: When sload_n is low at a rising edge, and clr_n and aload_n are high, count takes preset on that edge. This happens whether inhibit is high or low.
- R5: With inhibit high and all active-low controls high, count holds its value across clock edges.
- R6: term_n is low exactly when count is 8'h00 and inhibit is low. It follows inhibit without waiting for a clock.
- R7: From 00 with counting enabled, the next edge gives 99. A free run therefore shows term_n low once every 100 clocks.
- R8: preset[7:4] and count[7:4] carry the tens digit. preset[3:0] and count[3:0] carry the units digit.
- R9: When a second stage's inhibit is driven from a first stage's term_n, and both share the clock, the pair counts down through 10000 decimal states from 9999 to 0000 and then returns to 9999.
- R10: A digit value above 9, loaded through the preset bus, steps down in binary on each decrement of that digit until it reaches a BCD value. For example, 4C goes to 4B, and B0 goes to A9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to 99, active low, highest priority |
| aload_n | input | 1 | Asynchronous load of preset, active low |
| sload_n | input | 1 | Synchronous load of preset on the next rising edge, active low |
| inhibit | input | 1 | High stops counting and forces term_n high |
| preset | input | 8 | Two BCD digits to load, tens digit in the upper nibble |
| count | output | 8 | Current value as two BCD digits, tens digit in the upper nibble |
| term_n | output | 1 | Low when count is 00 and inhibit is low |

## Verification
The bench compares the counter against a decimal model over 250 free-running clocks, more than two full cycles. It also measures the spacing between terminal pulses. A missing or misplaced borrow shows up as a skipped or repeated value, and an 00-to-99 wrap that is off by one shows up as a wrong pulse spacing.

Several precedence cases are driven between clock edges:
- a clear and an immediate load asserted together;
- an immediate load held across an edge;
- a clocked load applied while counting is inhibited.

A wrong priority order would leave the value at the preset or at a decremented value instead of the expected one.

The bench also runs a two-stage synchronous cascade through all 10000 states. If the terminal flag were registered, or were not gated by inhibit, the upper stage would lag by one edge or would step on every wrap. Two non-BCD presets check that a digit above 9 steps down in binary.

// File: rtl/bcd_down_pkg.sv
// Package: shared constants and the single-digit decrement rule.
// Assumes 4-bit digits; values above 9 step down in binary.
package bcd_down_pkg;
    localparam int unsigned NIBBLE_W  = 4;
    localparam logic [3:0]  DIGIT_MAX = 4'd9;

    // One decrement of a digit: 0 wraps to 9, anything else drops by one.
    function automatic logic [3:0] digit_dec(input logic [3:0] d);
        return (d == 4'd0) ? DIGIT_MAX : d - 4'd1;
    endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
// Module: one BCD digit of the down counter.
// It holds the digit in a register that is cleared to 9 and loaded
// asynchronously. The visible digit bypasses to the preset while the
// immediate load is held. Assumes preset_d is stable while aload_n is low.
module bcd_digit_cell
    import bcd_down_pkg::*;
(
    input  logic                clk,
    input  logic                clr_n,
    input  logic                aload_n,
    input  logic                sload_n,
    input  logic                step_in,
    input  logic [NIBBLE_W-1:0] preset_d,
    output logic [NIBBLE_W-1:0] digit_o,
    output logic                zero_o
);
    logic [NIBBLE_W-1:0] q_r;
    logic                async_hit;

    // Digit state: clear, then immediate load, then clocked load, then step.
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n)
            q_r <= DIGIT_MAX;
        else if (!aload_n)
            q_r <= preset_d;
        else if (!sload_n)
            q_r <= preset_d;
        else if (step_in)
            q_r <= digit_dec(q_r);
    end

    // Marks a clock interval in which an asynchronous control was active.
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n || !aload_n)
            async_hit <= 1'b1;
        else
            async_hit <= 1'b0;
    end

    // Visible digit: the preset shows through while the immediate load is held.
    always_comb digit_o = (clr_n && !aload_n) ? preset_d : q_r;

    // Zero flag feeds the borrow chain and the terminal detector.
    always_comb zero_o = (digit_o == '0);

    assert_step_down_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && sload_n && step_in && q_r != '0)
        |=> (async_hit || q_r == 4'($past(q_r) - 4'd1)));

    assert_borrow_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && sload_n && step_in && q_r == '0)
        |=> (async_hit || q_r == DIGIT_MAX));

    assert_sync_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && !sload_n) |=> (async_hit || q_r == $past(preset_d)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && sload_n && !step_in) |=> (async_hit || $stable(q_r)));
endmodule

// File: rtl/bcd_term_detect.sv
// Module: terminal-count decode. The flag is low when every digit is zero
// and counting is allowed. It is purely combinational so that a
// downstream stage steps on the same edge on which this stage wraps.
module bcd_term_detect #(
    parameter int unsigned DIGITS = 2
) (
    input  logic [DIGITS-1:0] digit_zero,
    input  logic              inhibit,
    output logic              term_n
);
    // Active-low flag: all digits zero and counting enabled.
    always_comb term_n = ~((&digit_zero) & ~inhibit);
endmodule

// File: rtl/bcd_down_counter.sv
// Module: top of the cascadable BCD down counter.
// A generate loop builds DIGITS digit cells, and a borrow chain connects
// them. Clear gives the all-nines value, the all-zero value wraps to
// all-nines, and term_n is the cascade output. Assumes the asynchronous
// controls are released away from the clock edge.
module bcd_down_counter
    import bcd_down_pkg::*;
#(
    parameter int unsigned DIGITS = 2
) (
    input  logic                         clk,
    input  logic                         clr_n,
    input  logic                         aload_n,
    input  logic                         sload_n,
    input  logic                         inhibit,
    input  logic [DIGITS*NIBBLE_W-1:0]   preset,
    output logic [DIGITS*NIBBLE_W-1:0]   count,
    output logic                         term_n
);
    localparam int unsigned W = DIGITS * NIBBLE_W;
    localparam logic [W-1:0] ALL_NINES = {DIGITS{DIGIT_MAX}};

    logic [DIGITS:0]   step;
    logic [DIGITS-1:0] zero;

    // Units digit steps whenever counting is enabled.
    always_comb step[0] = ~inhibit;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        bcd_digit_cell u_cell (
            .clk      (clk),
            .clr_n    (clr_n),
            .aload_n  (aload_n),
            .sload_n  (sload_n),
            .step_in  (step[i]),
            .preset_d (preset[i*NIBBLE_W +: NIBBLE_W]),
            .digit_o  (count[i*NIBBLE_W +: NIBBLE_W]),
            .zero_o   (zero[i])
        );
        // Borrow to the next digit when this one steps from zero.
        always_comb step[i+1] = step[i] & zero[i];
    end

    bcd_term_detect #(.DIGITS(DIGITS)) u_term (
        .digit_zero (zero),
        .inhibit    (inhibit),
        .term_n     (term_n)
    );

    // Clear and immediate-load checks, sampled at each clock edge.
    always @(posedge clk) begin
        if (!clr_n)
            assert_clear_nines_R2: assert (count == ALL_NINES);
        else if (!aload_n)
            assert_async_load_R3: assert (count == preset);
    end

    assert_term_gated_R6: assert property (@(posedge clk) disable iff (!clr_n)
        inhibit |-> term_n);

    assert_term_nonzero_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (count != '0) |-> term_n);
endmodule

// File: tb/bcd_down_counter_bench.sv
// Bench: decimal reference model, free-run sweep, precedence cases,
// non-BCD presets and an exhaustive two-stage cascade.
module bcd_down_counter_bench;
    logic       clk = 1'b0;
    logic       clr_n, aload_n, sload_n, inhibit;
    logic [7:0] preset, count;
    logic       term_n;
    logic       c_clr_n, c_inh;
    logic [7:0] lo_count, hi_count;
    logic       lo_term, hi_term;
    int         errors = 0;
    int         checks = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    bcd_down_counter u_bcd_down_counter (
        .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
        .inhibit(inhibit), .preset(preset), .count(count), .term_n(term_n));

    bcd_down_counter u_casc_lo (
        .clk(clk), .clr_n(c_clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .inhibit(c_inh), .preset(8'h00), .count(lo_count), .term_n(lo_term));

    bcd_down_counter u_casc_hi (
        .clk(clk), .clr_n(c_clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .inhibit(lo_term), .preset(8'h00), .count(hi_count), .term_n(hi_term));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int rf;
        int last_tc;
        int cref;
        clr_n = 0; aload_n = 1; sload_n = 1; inhibit = 1; preset = 8'h00;
        c_clr_n = 0; c_inh = 1;
        @(negedge clk);
        @(negedge clk);
        check("R2 clear value", 16'(count), 16'h0099);
        check("R2 clear term", 16'(term_n), 16'h1);
        check("R2 cascade clear", {hi_count, lo_count}, 16'h9999);

        // R1 R7 R6: free run over more than two full cycles.
        clr_n = 1; inhibit = 0;
        rf = 99; last_tc = -1;
        for (int i = 0; i < 250; i++) begin
            tick();
            rf = (rf == 0) ? 99 : rf - 1;
            check("R1 free-run count", 16'(count), 16'(to_bcd(rf)));
            check("R6 free-run term", 16'(term_n), (rf == 0) ? 16'h0 : 16'h1);
            if (term_n == 1'b0) begin
                if (last_tc >= 0)
                    check("R7 cycle length", 16'(i - last_tc), 16'd100);
                last_tc = i;
            end
        end

        // R5: hold while inhibited.
        inhibit = 1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R5 hold", 16'(count), 16'(to_bcd(rf)));
        end

        // R4: clocked load works under inhibit; R6 gating by inhibit.
        preset = 8'h00; sload_n = 0;
        tick();
        check("R4 load under inhibit", 16'(count), 16'h0000);
        sload_n = 1;
        tick();
        check("R5 hold at zero", 16'(count), 16'h0000);
        check("R6 term gated by inhibit", 16'(term_n), 16'h1);
        inhibit = 0;
        #1;
        check("R6 term follows inhibit", 16'(term_n), 16'h0);
        tick();
        check("R7 wrap to 99", 16'(count), 16'h0099);

        // R4 R8: clocked load beats counting; digit layout.
        preset = 8'h57; sload_n = 0;
        tick();
        check("R4 load", 16'(count), 16'h0057);
        tick();
        check("R4 load beats count", 16'(count), 16'h0057);
        sload_n = 1;
        tick();
        check("R8 digit layout", 16'(count), 16'h0056);
        preset = 8'h20; sload_n = 0;
        tick();
        sload_n = 1;
        tick();
        check("R1 borrow into tens", 16'(count), 16'h0019);

        // R3: immediate load without and across a clock edge.
        #5 preset = 8'h83; aload_n = 0;
        #2 check("R3 immediate load", 16'(count), 16'h0083);
        @(posedge clk);
        #2 check("R3 load beats clock", 16'(count), 16'h0083);
        @(negedge clk);
        aload_n = 1;
        tick();
        check("R1 count after load", 16'(count), 16'h0082);

        // R2: mid-cycle clear, and clear over immediate load.
        #3 clr_n = 0;
        #2 check("R2 async clear", 16'(count), 16'h0099);
        aload_n = 0;
        #2 check("R2 clear beats load", 16'(count), 16'h0099);
        aload_n = 1;
        #2 clr_n = 1;
        @(negedge clk);
        check("R2 count after clear", 16'(count), 16'h0098);

        // R10: non-BCD digits step down in binary.
        preset = 8'h4C; sload_n = 0;
        tick();
        check("R10 load 4C", 16'(count), 16'h004C);
        sload_n = 1;
        tick();
        check("R10 4C to 4B", 16'(count), 16'h004B);
        tick();
        tick();
        check("R10 reach 49", 16'(count), 16'h0049);
        preset = 8'hB0; sload_n = 0;
        tick();
        sload_n = 1;
        tick();
        check("R10 B0 to A9", 16'(count), 16'h00A9);

        // R9: two-stage synchronous cascade through all states.
        c_clr_n = 1; c_inh = 0;
        cref = 9999;
        for (int i = 0; i < 10050; i++) begin
            tick();
            cref = (cref == 0) ? 9999 : cref - 1;
            check("R9 cascade count", {hi_count, lo_count},
                  {to_bcd(cref / 100), to_bcd(cref % 100)});
            check("R9 cascade term", 16'(hi_term), (cref == 0) ? 16'h0 : 16'h1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule